// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

This block is a real-time clock peripheral that runs from a 32.768 kHz low-speed clock. A down-counting prescaler divides that clock to a once-per-second tick. Each tick advances a 32-bit seconds counter. A 32-bit match register raises an alarm event when a tick moves the counter onto its value.

A four-bit status word holds two sticky event flags and the two interrupt enables that gate them onto two interrupt pins. The flags are cleared by writing ones. Each enable sits two bit positions above the flag it controls.

Software reaches the counter, the match value, the status word and a combined divisor/trim word through a simple register port. Writes are strobed and reads are combinational. If the divisor/trim word is entirely zero, the prescaler falls back to the divisor that suits a 32.768 kHz input. The trim half of that word is only stored and returned.

Top module: `rtc_seconds`

## Requirements
- R1: After reset, all four registers read zero and both interrupt outputs are low.
- R2: The register at address 0 is the seconds counter. A write loads it at the write edge and restarts the prescaler. The counter then increments once every divisor+1 clocks, with the first increment divisor+1 edges after the write, and it wraps from 0xFFFFFFFF to 0.
- R3: The register at address 3 holds the divisor in bits [15:0] and the trim value in bits [31:16]. Both fields read back exactly as written.
- R4: While the address-3 register is entirely zero, the prescaler uses divisor 32767, so increments are 32768 clocks apart.
- R5: Status (address 2) bit 1, the tick flag, is set on every edge at which the counter increments.
- R6: Status bit 0, the alarm flag, is set on the edge at which a tick moves the counter onto the value of the address-1 match register.
- R7: Writing 1 to status bit 0 or bit 1 clears that flag. Writing 0 to either bit leaves that flag as it was.
- R8: Status bit 2 (alarm enable) and bit 3 (tick enable) take the written value and read back.
- R9: The alarm interrupt is high exactly while the alarm flag and its enable are both set, and the tick interrupt likewise. Flags are recorded while their enable is clear, and a later enable raises the interrupt at once.
- R10: When a flag is set and cleared by a write at the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 counter, 1 match, 2 status, 3 divisor/trim |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_alarm | output | 1 | Alarm interrupt |
| irq_tick | output | 1 | Once-per-second interrupt |

## Verification
A write takes effect at its own clock edge. Register contents and both interrupt pins are therefore checked at the falling edge that follows it.

After a counter write with divisor D, increment k is due exactly k·(D+1) edges later. The bench counts falling edges from the write edge and compares the counter with W + floor(m/(D+1)) at every falling edge of a sweep that crosses the wrap.

Flag checks are placed one edge before and one edge after the predicted tick or alarm edge. The set-versus-clear case is exercised by timing the clearing write onto a tick edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] A_MATCH  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STATUS = 2'd2;
  localparam logic [ADDR_W-1:0] A_DIVTRM = 2'd3;

  // event channel indices; enable of channel i sits at status bit i+N_EVT
  localparam int N_EVT  = 2;
  localparam int EV_ALM = 0;
  localparam int EV_SEC = 1;
  localparam int STAT_W = 2 * N_EVT;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W   = 16,
  parameter int DEF_DIV = 32767
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             use_default,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  localparam logic [DIV_W-1:0] DEF_V = DIV_W'(DEF_DIV);

  logic [DIV_W-1:0] cnt_q, cnt_d, eff_div;
  logic             at_zero;

  always_comb begin
    eff_div = use_default ? DEF_V : divisor;
    at_zero = (cnt_q == '0);
    tick    = at_zero && !restart;
    if (restart || at_zero) cnt_d = eff_div;
    else                    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= DEF_V;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtc_status.sv
module rtc_status
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [STAT_W-1:0] wdata,
  input  logic [N_EVT-1:0]  evt,
  output logic [N_EVT-1:0]  flag,
  output logic [N_EVT-1:0]  en,
  output logic [N_EVT-1:0]  irq
);
  logic [N_EVT-1:0] flag_d, en_d;

  always_comb begin
    for (int i = 0; i < N_EVT; i++) begin
      flag_d[i] = flag[i];
      if (wr && wdata[i]) flag_d[i] = 1'b0;
      if (evt[i])         flag_d[i] = 1'b1;   // event beats clear
    end
    en_d = en;
    if (wr) en_d = wdata[STAT_W-1:N_EVT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= '0;
      en   <= '0;
    end else begin
      flag <= flag_d;
      if (wr) en <= en_d;
    end
  end

  for (genvar g = 0; g < N_EVT; g++) begin : g_irq
    assign irq[g] = flag[g] & en[g];
  end
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds
  import rtc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 16,
  parameter int DEF_DIV = 32767
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_alarm,
  output logic              irq_tick
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  logic              wr_cnt, wr_match, wr_stat, wr_div;
  logic [DATA_W-1:0] sec_q, sec_d, match_q, divtrm_q;
  logic              tick, alarm_evt;
  logic [N_EVT-1:0]  evt, flag, en, irq;

  always_comb begin
    wr_cnt   = reg_we && (reg_addr == A_COUNT);
    wr_match = reg_we && (reg_addr == A_MATCH);
    wr_stat  = reg_we && (reg_addr == A_STATUS);
    wr_div   = reg_we && (reg_addr == A_DIVTRM);
  end

  rtc_prescaler #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_pre (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .restart     (wr_cnt),
    .use_default (divtrm_q == '0),
    .divisor     (divtrm_q[DIV_W-1:0]),
    .tick        (tick)
  );

  always_comb begin
    if (wr_cnt)    sec_d = reg_wdata;
    else if (tick) sec_d = sec_q + 1'b1;
    else           sec_d = sec_q;
    alarm_evt      = tick && ((sec_q + 1'b1) == match_q);
    evt            = '0;
    evt[EV_ALM]    = alarm_evt;
    evt[EV_SEC]    = tick;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      sec_q    <= '0;
      match_q  <= '0;
      divtrm_q <= '0;
    end else begin
      if (wr_cnt || tick) sec_q    <= sec_d;
      if (wr_match)       match_q  <= reg_wdata;
      if (wr_div)         divtrm_q <= reg_wdata;
    end
  end

  rtc_status u_stat (
    .clk   (clk),
    .rst_n (rst_i_n),
    .wr    (wr_stat),
    .wdata (reg_wdata[STAT_W-1:0]),
    .evt   (evt),
    .flag  (flag),
    .en    (en),
    .irq   (irq)
  );

  assign irq_alarm = irq[EV_ALM];
  assign irq_tick  = irq[EV_SEC];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_COUNT:  reg_rdata = sec_q;
      A_MATCH:  reg_rdata = match_q;
      A_STATUS: reg_rdata[STAT_W-1:0] = {en, flag};
      default:  reg_rdata = divtrm_q;
    endcase
  end
endmodule

// File: rtl/rtc_seconds_chk.sv
module rtc_seconds_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_cnt,
  input logic              wr_stat,
  input logic [DATA_W-1:0] sec_q,
  input logic [DATA_W-1:0] match_q,
  input logic [1:0]        flag,
  input logic [1:0]        en,
  input logic              irq_alarm,
  input logic              irq_tick
);
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt) |=> (sec_q == $past(sec_q) + 1'b1));

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(sec_q));

  a_r5_tick_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> flag[1]);

  a_r6_alarm_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (sec_q + 1'b1 == match_q)) |=> flag[0]);

  a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_stat) |=> $stable(flag));

  a_r9_alarm_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_alarm |-> (en[0] && flag[0]));

  a_r9_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tick |-> (en[1] && flag[1]));
endmodule

bind rtc_seconds rtc_seconds_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_i_n),
  .tick      (tick),
  .wr_cnt    (wr_cnt),
  .wr_stat   (wr_stat),
  .sec_q     (sec_q),
  .match_q   (match_q),
  .flag      (flag),
  .en        (en),
  .irq_alarm (irq_alarm),
  .irq_tick  (irq_tick)
);

// File: tb/sim_rtc_seconds.sv
module sim_rtc_seconds;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 200000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_alarm, irq_tick;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_seconds u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_alarm(irq_alarm), .irq_tick(irq_tick)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYC);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reg", v, 32'h0);
    end
    chk("R1 irq_alarm", {31'b0, irq_alarm}, 32'h0);
    chk("R1 irq_tick", {31'b0, irq_tick}, 32'h0);

    // R4 zero divisor word falls back to 32768-clock period
    wr(2'd0, 32'h0);
    idle(32767);
    rd(2'd0, v); chk("R4 before tick", v, 32'h0);
    idle(1);
    rd(2'd0, v); chk("R4 at tick", v, 32'h1);
    rd(2'd2, v); chk("R5 flag after default tick", v & 32'h2, 32'h2);

    // R3 divisor/trim readback (divisor 3 -> period 4)
    wr(2'd3, 32'h00A5_0003);
    rd(2'd3, v); chk("R3 readback", v, 32'h00A5_0003);

    // R2 sweep across the wrap
    wr(2'd0, 32'hFFFF_FFFE);
    for (int m = 1; m <= 14; m++) begin
      idle(1);
      rd(2'd0, v);
      chk("R2 count sweep", v, 32'hFFFF_FFFE + 32'(m / 4));
    end

    // R7 zero write keeps flag, one write clears it; R5 set on tick
    wr(2'd2, 32'h0);
    rd(2'd2, v); chk("R7 zero write keeps flag", v & 32'h2, 32'h2);
    wr(2'd0, 32'h0);            // edge E0
    wr(2'd2, 32'h2);            // edge E0+1
    rd(2'd2, v); chk("R7 clear", v & 32'h2, 32'h0);
    idle(2);                    // after E0+3
    rd(2'd2, v); chk("R5 no flag before tick", v & 32'h2, 32'h0);
    idle(1);                    // after E0+4
    rd(2'd2, v); chk("R5 flag at tick", v & 32'h2, 32'h2);
    idle(3);                    // after E0+7
    wr(2'd2, 32'h2);            // clear at E0+8, a tick edge
    rd(2'd2, v); chk("R10 set wins", v & 32'h2, 32'h2);
    rd(2'd0, v); chk("R2 count after restart", v, 32'h2);

    // R9 gating of the tick interrupt, R8 enable readback
    chk("R9 tick irq off while disabled", {31'b0, irq_tick}, 32'h0);
    wr(2'd2, 32'h8);
    chk("R9 tick irq on enable", {31'b0, irq_tick}, 32'h1);
    rd(2'd2, v); chk("R8 enable bits", v & 32'hC, 32'h8);
    wr(2'd2, 32'h0);
    chk("R9 tick irq off", {31'b0, irq_tick}, 32'h0);
    rd(2'd2, v); chk("R8 enables cleared", v & 32'hC, 32'h0);

    // R6 alarm match, R9 alarm gating, R7 clear with enable kept
    wr(2'd1, 32'd5);
    rd(2'd1, v); chk("R6 match readback", v, 32'd5);
    wr(2'd0, 32'd3);            // edge E0
    wr(2'd2, 32'h3);            // edge E0+1, clear both
    idle(6);                    // after E0+7
    rd(2'd2, v); chk("R6 no alarm yet", v & 32'h1, 32'h0);
    rd(2'd0, v); chk("R2 count before alarm", v, 32'd4);
    idle(1);                    // after E0+8
    rd(2'd2, v); chk("R6 alarm flag", v & 32'h1, 32'h1);
    rd(2'd0, v); chk("R2 count at alarm", v, 32'd5);
    chk("R9 alarm irq off while disabled", {31'b0, irq_alarm}, 32'h0);
    wr(2'd2, 32'h4);
    chk("R9 alarm irq on enable", {31'b0, irq_alarm}, 32'h1);
    wr(2'd2, 32'h5);
    chk("R7 alarm cleared irq", {31'b0, irq_alarm}, 32'h0);
    rd(2'd2, v); chk("R8 alarm enable kept", v & 32'h5, 32'h4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule